// File: doc/BRIEF.md
# DMA Byte Counter with Staged Reload

This block holds the byte count for the DMA engine of a bus controller. Software programs the count one byte at a time into a staging copy. The staging copy has no effect on the count that is running. The working count changes only when a command carrying the DMA flag is issued. At that point the staged value is copied in, any earlier completion status is cleared, and the counter becomes active.

While active, the counter drops by the number of bytes that the DMA side reports on a one-cycle strobe. It never goes below zero. On the clock edge where the count reaches zero, the block sets terminal count and bus-service together, and the counter goes idle.

For every burst, the block also offers a grant length. This is the smaller of the bytes still to move and the bytes left in the current phase. In the command phase, the bytes left in the phase are fixed at the capacity of the command buffer. A staged value of zero means the largest count, 2^CNT_W bytes.

Top module: `xfer_count_ctl`

## Requirements
- R1: After reset, the staged count, working count, grant, terminal count, bus-service and active outputs are all zero.
- R2: A host write with select 0, 1 or 2 stores the data byte in bits [7:0], [15:8] or [23:16] of the staged count. Select 3 changes nothing.
- R3: Host writes never change the working count.
- R4: When `cmd_issue` and `cmd_dma` are both high, the staged count is copied into the working count and `active` rises on the next edge. With `cmd_dma` low, `cmd_issue` has no effect.
- R5: A DMA command load clears `term_cnt` and `bus_svc`.
- R6: A staged count of zero loads 2^24. The working count then reads 0 while `active` is 1, and the grant is limited only by the phase length.
- R7: A done strobe while active lowers the working count by `done_bytes` and saturates at zero. A strobe of zero bytes leaves the count unchanged.
- R8: On the edge where the count reaches zero, `term_cnt` and `bus_svc` become 1, `active` becomes 0 and the working count reads 0.
- R9: `grant_len` is the minimum of the working count and the phase remainder. The phase remainder is `phase_remain` in a data phase and CMDBUF_BYTES (16) when `cmd_phase` is 1. `grant_len` is 0 while idle.
- R10: Done strobes while idle change neither the count nor the status.
- R11: When a load and a done strobe arrive in the same cycle, the load wins and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Byte lane select (0 low, 1 middle, 2 high) |
| host_wdata | input | 8 | Host write data |
| cmd_issue | input | 1 | Command written this cycle |
| cmd_dma | input | 1 | The command carries the DMA flag |
| cmd_phase | input | 1 | Bus is in command phase |
| phase_remain | input | 24 | Bytes left in the current data phase |
| done_vld | input | 1 | DMA side moved bytes this cycle |
| done_bytes | input | 16 | Bytes moved |
| stage_count | output | 24 | Staged count |
| work_count | output | 24 | Readable working count |
| grant_len | output | 25 | Burst length granted |
| term_cnt | output | 1 | Terminal count status |
| bus_svc | output | 1 | Bus-service interrupt cause |
| active | output | 1 | Transfer in progress |

## Verification
A wrong staged byte lane appears on `stage_count` one edge after the host write. It also appears on `work_count` one edge after the next DMA command. A counter that loses track of the working count shows up at the next done strobe. The value read back is wrong, or `term_cnt` rises one edge early or late compared with the byte total. A wrong minimum, or a mis-handled zero count, is visible on `grant_len` in the cycle right after the load, before any bytes have moved.

// File: rtl/xfer_cnt_pkg.sv
package xfer_cnt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic active;
    logic tc;
    logic bsvc;
  } xfer_stat_t;
endpackage

// File: rtl/xfer_stage_regs.sv
module xfer_stage_regs #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned SEL_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [SEL_W-1:0]              sel,
  input  logic [xfer_cnt_pkg::BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]              stage_q
);
  localparam int unsigned NBYTES = CNT_W / xfer_cnt_pkg::BYTE_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g*xfer_cnt_pkg::BYTE_W +: xfer_cnt_pkg::BYTE_W] <= '0;
      end else if (wr && (sel == SEL_W'(g))) begin
        stage_q[g*xfer_cnt_pkg::BYTE_W +: xfer_cnt_pkg::BYTE_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/xfer_work_counter.sv
module xfer_work_counter #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned BEAT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [CNT_W-1:0]        stage,
  input  logic                    done_vld,
  input  logic [BEAT_W-1:0]       done_bytes,
  output logic [CNT_W:0]          cnt_q,
  output xfer_cnt_pkg::xfer_stat_t stat_q,
  output logic                    hit_zero
);
  // A staged zero means the full 2^CNT_W range.
  function automatic logic [CNT_W:0] f_effective(input logic [CNT_W-1:0] s);
    return (s == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, s};
  endfunction

  // Subtract without going below zero.
  function automatic logic [CNT_W:0] f_sat_sub(input logic [CNT_W:0] a,
                                              input logic [BEAT_W-1:0] b);
    logic [CNT_W:0] bx;
    bx = (CNT_W+1)'(b);
    return (bx >= a) ? '0 : (a - bx);
  endfunction

  logic           dec_ok;
  logic [CNT_W:0] cnt_next;

  assign dec_ok   = done_vld && stat_q.active && !load;
  assign cnt_next = f_sat_sub(cnt_q, done_bytes);
  assign hit_zero = dec_ok && (cnt_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= '0;
    end else if (load) begin
      cnt_q       <= f_effective(stage);
      stat_q.active <= 1'b1;
      stat_q.tc     <= 1'b0;
      stat_q.bsvc   <= 1'b0;
    end else if (dec_ok) begin
      cnt_q <= cnt_next;
      if (hit_zero) begin
        stat_q.active <= 1'b0;
        stat_q.tc     <= 1'b1;
        stat_q.bsvc   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfer_grant_calc.sv
module xfer_grant_calc #(
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned CMDBUF_BYTES = 16
) (
  input  logic             active,
  input  logic [CNT_W:0]   cnt,
  input  logic             cmd_phase,
  input  logic [CNT_W-1:0] phase_remain,
  output logic [CNT_W:0]   grant
);
  function automatic logic [CNT_W:0] f_min(input logic [CNT_W:0] a,
                                          input logic [CNT_W:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [CNT_W:0] remain_eff;

  assign remain_eff = cmd_phase ? (CNT_W+1)'(CMDBUF_BYTES) : {1'b0, phase_remain};
  assign grant      = active ? f_min(cnt, remain_eff) : '0;
endmodule

// File: rtl/xfer_count_ctl.sv
module xfer_count_ctl #(
  parameter int unsigned CNT_W        = 24,
  parameter int unsigned BEAT_W       = 16,
  parameter int unsigned CMDBUF_BYTES = 16,
  parameter int unsigned SEL_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [7:0]        host_wdata,
  input  logic              cmd_issue,
  input  logic              cmd_dma,
  input  logic              cmd_phase,
  input  logic [CNT_W-1:0]  phase_remain,
  input  logic              done_vld,
  input  logic [BEAT_W-1:0] done_bytes,
  output logic [CNT_W-1:0]  stage_count,
  output logic [CNT_W-1:0]  work_count,
  output logic [CNT_W:0]    grant_len,
  output logic              term_cnt,
  output logic              bus_svc,
  output logic              active
);
  import xfer_cnt_pkg::*;

  // Named internal events for the checker.
  logic           load_fire;
  logic           hit_zero;
  logic [CNT_W:0] work_full;
  xfer_stat_t     stat;

  assign load_fire = cmd_issue && cmd_dma;

  xfer_stage_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (host_wr),
    .sel     (host_sel),
    .wdata   (host_wdata),
    .stage_q (stage_count)
  );

  xfer_work_counter #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_work (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_fire),
    .stage      (stage_count),
    .done_vld   (done_vld),
    .done_bytes (done_bytes),
    .cnt_q      (work_full),
    .stat_q     (stat),
    .hit_zero   (hit_zero)
  );

  xfer_grant_calc #(.CNT_W(CNT_W), .CMDBUF_BYTES(CMDBUF_BYTES)) u_grant (
    .active       (stat.active),
    .cnt          (work_full),
    .cmd_phase    (cmd_phase),
    .phase_remain (phase_remain),
    .grant        (grant_len)
  );

  assign work_count = work_full[CNT_W-1:0];
  assign term_cnt   = stat.tc;
  assign bus_svc    = stat.bsvc;
  assign active     = stat.active;
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_fire,
  input logic             hit_zero,
  input logic [CNT_W:0]   work_full,
  input logic [CNT_W-1:0] stage_count,
  input logic [CNT_W:0]   grant_len,
  input logic             term_cnt,
  input logic             bus_svc,
  input logic             active
);
  a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> active && (work_full == (($past(stage_count) == '0) ?
      {1'b1, {CNT_W{1'b0}}} : {1'b0, $past(stage_count)})));

  a_r5_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !term_cnt && !bus_svc);

  a_r7_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> work_full <= $past(work_full));

  a_r8_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
    hit_zero |=> term_cnt && bus_svc && !active && (work_full == '0));

  a_r9_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
    grant_len <= work_full);

  a_r9_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> grant_len == '0);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load_fire) |=> $stable(work_full) && !active);
endmodule

bind xfer_count_ctl xfer_count_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_fire   (load_fire),
  .hit_zero    (hit_zero),
  .work_full   (work_full),
  .stage_count (stage_count),
  .grant_len   (grant_len),
  .term_cnt    (term_cnt),
  .bus_svc     (bus_svc),
  .active      (active)
);

// File: tb/xfer_count_ctl_test.sv
module xfer_count_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [7:0]  host_wdata = '0;
  logic        cmd_issue = 1'b0;
  logic        cmd_dma = 1'b0;
  logic        cmd_phase = 1'b0;
  logic [23:0] phase_remain = '0;
  logic        done_vld = 1'b0;
  logic [15:0] done_bytes = '0;
  logic [23:0] stage_count;
  logic [23:0] work_count;
  logic [24:0] grant_len;
  logic        term_cnt;
  logic        bus_svc;
  logic        active;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xfer_count_ctl uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .cmd_issue(cmd_issue), .cmd_dma(cmd_dma),
    .cmd_phase(cmd_phase), .phase_remain(phase_remain), .done_vld(done_vld),
    .done_bytes(done_bytes), .stage_count(stage_count), .work_count(work_count),
    .grant_len(grant_len), .term_cnt(term_cnt), .bus_svc(bus_svc), .active(active)
  );

  typedef struct packed {
    logic [23:0] stage;
    logic        cmdph;
    logic [23:0] remain;
    logic [15:0] dec;
    logic [24:0] exp_grant;
    logic [23:0] exp_work;
    logic        exp_tc;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{24'h000100, 1'b0, 24'd100,    16'd56,   25'd100,      24'd200,    1'b0},
    '{24'h000010, 1'b0, 24'd1000,   16'd16,   25'd16,       24'd0,      1'b1},
    '{24'h123456, 1'b1, 24'd5,      16'h0056, 25'd16,       24'h123400, 1'b0},
    '{24'h000005, 1'b0, 24'd9,      16'd10,   25'd5,        24'd0,      1'b1},
    '{24'h000000, 1'b0, 24'hFFFFFF, 16'd1,    25'h0FFFFFF,  24'hFFFFFF, 1'b0},
    '{24'hFFFFFF, 1'b0, 24'h000020, 16'hFFFF, 25'h20,       24'hFF0000, 1'b0},
    '{24'h000003, 1'b1, 24'd0,      16'd3,    25'd3,        24'd0,      1'b1}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic issue(input logic dma);
    cmd_issue = 1'b1; cmd_dma = dma;
    tick();
    cmd_issue = 1'b0; cmd_dma = 1'b0;
  endtask

  task automatic pulse_done(input logic [15:0] n);
    done_vld = 1'b1; done_bytes = n;
    tick();
    done_vld = 1'b0; done_bytes = '0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stage", 32'(stage_count), 32'h0);
    chk("R1 work", 32'(work_count), 32'h0);
    chk("R1 flags", {29'h0, term_cnt, bus_svc, active}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R2: byte lanes; select 3 ignored
    host_write(2'd0, 8'h11);
    host_write(2'd1, 8'h22);
    host_write(2'd2, 8'h33);
    chk("R2 lanes", 32'(stage_count), 32'h332211);
    host_write(2'd3, 8'hEE);
    chk("R2 sel3 ignored", 32'(stage_count), 32'h332211);
    chk("R3 idle work untouched", 32'(work_count), 32'h0);

    // R4: command without the DMA flag does not load
    issue(1'b0);
    chk("R4 no dma no load", {7'h0, active, work_count}, 32'h0);
    issue(1'b1);
    chk("R4 dma load", {7'h0, active, work_count}, {8'h01, 24'h332211});

    // R3: host write while active leaves the working count
    host_write(2'd0, 8'h99);
    chk("R3 stage updated", 32'(stage_count), 32'h332299);
    chk("R3 work unchanged", 32'(work_count), 32'h332211);

    // R7: zero-byte strobe
    pulse_done(16'd0);
    chk("R7 zero strobe", 32'(work_count), 32'h332211);

    // R11: load and strobe together, load wins
    cmd_issue = 1'b1; cmd_dma = 1'b1; done_vld = 1'b1; done_bytes = 16'h0100;
    tick();
    cmd_issue = 1'b0; cmd_dma = 1'b0; done_vld = 1'b0; done_bytes = '0;
    chk("R11 load wins", 32'(work_count), 32'h332299);

    // Table: R6 R7 R8 R9 R5
    for (int i = 0; i < NV; i++) begin
      host_write(2'd0, VECS[i].stage[7:0]);
      host_write(2'd1, VECS[i].stage[15:8]);
      host_write(2'd2, VECS[i].stage[23:16]);
      cmd_phase = VECS[i].cmdph;
      phase_remain = VECS[i].remain;
      issue(1'b1);
      chk("R9 R6 grant", 32'(grant_len), 32'(VECS[i].exp_grant));
      chk("R5 cleared on load", {30'h0, term_cnt, bus_svc}, 32'h0);
      pulse_done(VECS[i].dec);
      chk("R7 work after strobe", 32'(work_count), 32'(VECS[i].exp_work));
      chk("R8 term and service", {29'h0, term_cnt, bus_svc, active},
          VECS[i].exp_tc ? 32'h6 : 32'h1);
    end

    // R10: strobe while idle (last vector ended at zero)
    pulse_done(16'd5);
    chk("R10 idle strobe", {5'h0, term_cnt, bus_svc, active, work_count}, {8'h06, 24'h0});
    chk("R9 idle grant", 32'(grant_len), 32'h0);

    report();
  end
endmodule